// File: doc/BRIEF.md
# Latin-Square Adjacent-Error Memory Codec

This block protects a 16-bit memory word with 12 check bits. Each word is stored as 28 bits. The data bits are seen as a 4x4 square. Each group of four consecutive data bits forms one row of that square.

The check bits come from three families of four parity equations. Each equation is a Latin-square line through the square, and the family that would tie a group's bits together is left out. As a result, two bits of the same group never share a check. Any two bits from different groups share at most one check, and each data bit sits in exactly three checks.

The encoder side turns a data word into its check bits. The decoder side takes a stored 28-bit word and recomputes the syndrome. It inverts every data bit whose three checks all fail. It then re-encodes the inversions to confirm that they explain the syndrome. If they do not, the word is reported as uncorrectable instead of being silently changed. An optional output register gives both sides one cycle of latency.

Top module: `lsq_codec`

## Requirements
- R1: The stored word holds the data in bits [15:0] and the checks in bits [27:16]. Data bit i = 4g + c belongs to group g and column c. Check k in 0..3 is the XOR of the data bits with c = k. Check 4+r is the XOR of the data bits with (c XOR g) = r. Check 8+r is the XOR of the data bits with (c XOR 2·g) = r, where 2·g is the GF(4) product (0,1,2,3 map to 0,2,3,1).
- R2: A word whose syndrome is zero returns its data unchanged with both flags low.
- R3: Any single data-bit error is corrected, and the corrected flag rises.
- R4: Any single check-bit error returns the data unchanged with the corrected flag high and the fail flag low.
- R5: A data bit is inverted only when all three of its checks fail, so a syndrome of weight below three never alters the data.
- R6: Any two errors inside one data group are both corrected, with the corrected flag high.
- R7: Two data errors in different groups that share a check are reported with the fail flag.
- R8: Two data errors in different groups that share no check are corrected.
- R9: A data error plus an error on one of that bit's own checks raises the fail flag. A data error plus an error on any other check is corrected.
- R10: Any two check-bit errors raise the fail flag.
- R11: The corrected and fail flags are never high together. While fail is high, the data output equals the stored data field exactly.
- R12: With the output register enabled, every output follows its inputs one clock later. An active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 16 | Data word to encode |
| enc_check_o | output | 12 | Check bits for enc_data_i |
| dec_word_i | input | 28 | Stored word to decode (checks in the upper 12 bits) |
| dec_data_o | output | 16 | Corrected data |
| dec_fixed_o | output | 1 | A correctable error was found and handled |
| dec_fail_o | output | 1 | An uncorrectable error pattern was detected |

## Verification
The assertions check four properties on every cycle:
- A zero syndrome leaves the flags and the inversion mask quiet.
- A syndrome lighter than three bits never inverts data.
- The two flags are never high together.
- A registered fail passes the stored data field through unaltered.

Whether a given error pattern is repaired or refused depends on how the three check families overlap. Only the bench's sweep shows this. It injects every single error and every error pair into several data words and compares each decode against the class of that pair: same group, shared check, own check, or two checks.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int SQ      = 4;             // square order (group size)
    localparam int SUBS    = 3;             // parity families kept
    localparam int DATA_W  = SQ * SQ;
    localparam int CHK_W   = SUBS * SQ;
    localparam int WORD_W  = DATA_W + CHK_W;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
        logic              fixed;
        logic              fail;
    } lsq_out_t;

    // multiply by the generator in GF(4) (x^2 + x + 1)
    function automatic logic [1:0] gf_dbl(input logic [1:0] v);
        return {v[1] ^ v[0], v[1]};
    endfunction

    // index of the check in family fam that covers data bit bit_i
    function automatic int chk_index(input int fam, input int bit_i);
        logic [1:0] g;
        logic [1:0] c;
        logic [1:0] r;
        g = 2'(bit_i / SQ);
        c = 2'(bit_i % SQ);
        case (fam)
            0:       r = c;
            1:       r = c ^ g;
            default: r = c ^ gf_dbl(g);
        endcase
        return fam * SQ + int'(r);
    endfunction

    // data-bit mask of one check equation
    function automatic logic [DATA_W-1:0] cover_mask(input int k);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (chk_index(k / SQ, i) == k) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lsq_encoder.sv
module lsq_encoder
    import lsq_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [DATA_W-1:0] MASK = cover_mask(k);
        assign chk_o[k] = ^(data_i & MASK);
    end

endmodule

// File: rtl/lsq_vote.sv
module lsq_vote
    import lsq_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] flip_o
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [SUBS-1:0] hit;
        for (genvar s = 0; s < SUBS; s++) begin : g_fam
            localparam int IDX = chk_index(s, i);
            assign hit[s] = syn_i[IDX];
        end
        // unanimous vote: all three equations must fail
        assign flip_o[i] = &hit;
    end

endmodule

// File: rtl/lsq_judge.sv
module lsq_judge
    import lsq_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    input  logic [CHK_W-1:0]  resid_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] flip_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fixed_o,
    output logic              fail_o
);

    logic any_err;
    logic light;

    always_comb begin
        any_err = |syn_i;
        // residual of weight zero or one is explained by the inversions
        light   = ((resid_i & (resid_i - 1'b1)) == '0);
        fixed_o = any_err & light;
        fail_o  = any_err & ~light;
        data_o  = fail_o ? raw_i : (raw_i ^ flip_i);
    end

endmodule

// File: rtl/lsq_codec.sv
module lsq_codec
    import lsq_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_check_o,
    input  logic [WORD_W-1:0] dec_word_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_fixed_o,
    output logic              dec_fail_o
);

    logic [DATA_W-1:0] raw_data;
    logic [CHK_W-1:0]  raw_chk;
    logic [CHK_W-1:0]  enc_chk;
    logic [CHK_W-1:0]  recomp_chk;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic [CHK_W-1:0]  flip_chk;
    logic [CHK_W-1:0]  resid;
    logic [DATA_W-1:0] fix_data;
    logic              fix_flag;
    logic              fail_flag;
    lsq_out_t          out_d;
    lsq_out_t          out_q;

    assign raw_data = dec_word_i[DATA_W-1:0];
    assign raw_chk  = dec_word_i[WORD_W-1:DATA_W];

    lsq_encoder u_enc_wr (.data_i(enc_data_i), .chk_o(enc_chk));
    lsq_encoder u_enc_rd (.data_i(raw_data),   .chk_o(recomp_chk));

    assign syn = raw_chk ^ recomp_chk;

    lsq_vote u_vote (.syn_i(syn), .flip_o(flip));

    // re-encode the inversions; what they leave unexplained is the residual
    lsq_encoder u_enc_flip (.data_i(flip), .chk_o(flip_chk));
    assign resid = syn ^ flip_chk;

    lsq_judge u_judge (
        .syn_i   (syn),
        .resid_i (resid),
        .raw_i   (raw_data),
        .flip_i  (flip),
        .data_o  (fix_data),
        .fixed_o (fix_flag),
        .fail_o  (fail_flag)
    );

    always_comb begin
        out_d       = out_q;
        out_d.chk   = enc_chk;
        out_d.data  = fix_data;
        out_d.fixed = fix_flag;
        out_d.fail  = fail_flag;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        // R11: a reported failure hands back the stored data field untouched
        a_r11_raw_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
            out_q.fail |-> (out_q.data == $past(dec_word_i[DATA_W-1:0])));
    end else begin : g_comb
        always_comb out_q = out_d;
    end

    assign enc_check_o = out_q.chk;
    assign dec_data_o  = out_q.data;
    assign dec_fixed_o = out_q.fixed;
    assign dec_fail_o  = out_q.fail;

    // R2: a clean syndrome raises nothing and inverts nothing
    a_r2_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (syn == '0) |-> (!fix_flag && !fail_flag && flip == '0));

    // R5: fewer than three failing checks can never satisfy a unanimous vote
    a_r5_light_syndrome_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(syn) < 3) |-> (flip == '0));

    // R11: the two flags exclude each other at the outputs
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_fixed_o && dec_fail_o));

endmodule

// File: tb/tb_lsq_codec.sv
`timescale 1ns/1ps
module tb_lsq_codec;
    import lsq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] enc_data;
    logic [WORD_W-1:0] word;
    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] dout;
    logic              fixed;
    logic              fail;
    int                nvec = 0;
    int                nbad = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    lsq_codec dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enc_data_i  (enc_data),
        .enc_check_o (enc_chk),
        .dec_word_i  (word),
        .dec_data_o  (dout),
        .dec_fixed_o (fixed),
        .dec_fail_o  (fail)
    );

    function automatic int dbl(input int g);
        return (g < 2) ? 2 * g : ((2 * g - 4) ^ 3);
    endfunction

    function automatic bit covers(input int k, input int i);
        int g, c, fam, r;
        g = i / 4; c = i % 4; fam = k / 4; r = k % 4;
        if (fam == 0) return c == r;
        if (fam == 1) return (c ^ g) == r;
        return (c ^ dbl(g)) == r;
    endfunction

    function automatic logic [CHK_W-1:0] ref_chk(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] x;
        x = '0;
        for (int k = 0; k < CHK_W; k++)
            for (int i = 0; i < DATA_W; i++)
                if (covers(k, i)) x[k] = x[k] ^ d[i];
        return x;
    endfunction

    function automatic int shared(input int p, input int q);
        int n;
        n = 0;
        for (int k = 0; k < CHK_W; k++)
            if (covers(k, p) && covers(k, q)) n++;
        return n;
    endfunction

    task automatic note(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [DATA_W-1:0] d, input logic [WORD_W-1:0] w);
        @(negedge clk);
        enc_data = d;
        word     = w;
        @(negedge clk);
    endtask

    task automatic expect_dec(input string req, input logic [WORD_W-1:0] w,
                              input bit efail, input bit efix, input logic [DATA_W-1:0] edata);
        step(16'h0, w);
        note({fail, fixed, dout} == {efail, efix, edata}, req,
             {fail, fixed, dout}, {efail, efix, edata});
    endtask

    initial begin
        logic [DATA_W-1:0] w;
        logic [WORD_W-1:0] cw;
        logic [WORD_W-1:0] bad;
        enc_data = '0;
        word     = '0;
        repeat (3) @(negedge clk);
        note({fail, fixed, dout} == 18'h0 && enc_chk == '0, "R12 reset",
             {fail, fixed, dout}, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        enc_data = 16'h1234;
        word     = {ref_chk(16'h1234), 16'h1234} ^ 28'h1;
        #1;
        note(dout == 16'h0 && !fixed, "R12 held before edge", {fail, fixed, dout}, 18'h0);
        @(negedge clk);
        note(dout == 16'h1234 && fixed && !fail, "R12 after edge",
             {fail, fixed, dout}, {2'b01, 16'h1234});

        for (int t = 0; t < 10; t++) begin
            w  = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : (t == 2) ? 16'hA5C3 : 16'($urandom());
            cw = {ref_chk(w), w};
            step(w, cw);
            note(enc_chk == ref_chk(w), "R1 encode", 18'(enc_chk), 18'(ref_chk(w)));
            note({fail, fixed, dout} == {2'b00, w}, "R2 clean", {fail, fixed, dout}, {2'b00, w});

            for (int p = 0; p < WORD_W; p++) begin
                bad = cw ^ (28'h1 << p);
                expect_dec((p < DATA_W) ? "R3 single data" : "R4 R5 single check",
                           bad, 1'b0, 1'b1, w);
            end

            for (int p = 0; p < WORD_W; p++) begin
                for (int q = p + 1; q < WORD_W; q++) begin
                    bad = cw ^ (28'h1 << p) ^ (28'h1 << q);
                    if (q < DATA_W) begin
                        if (p / 4 == q / 4)
                            expect_dec("R6 in-group pair", bad, 1'b0, 1'b1, w);
                        else if (shared(p, q) > 0)
                            expect_dec("R7 R11 shared-check pair", bad, 1'b1, 1'b0, bad[DATA_W-1:0]);
                        else
                            expect_dec("R8 disjoint pair", bad, 1'b0, 1'b1, w);
                    end else if (p < DATA_W) begin
                        if (covers(q - DATA_W, p))
                            expect_dec("R9 R11 data plus own check", bad, 1'b1, 1'b0, bad[DATA_W-1:0]);
                        else
                            expect_dec("R9 data plus other check", bad, 1'b0, 1'b1, w);
                    end else begin
                        expect_dec("R10 R5 R11 two checks", bad, 1'b1, 1'b0, bad[DATA_W-1:0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL R12 watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule